// File: doc/BRIEF.md
# Boot Retention Copy Engine

This block keeps a short boot program in a small word-addressed memory that stays powered while the processor next to it sleeps. On request it copies a run of that program, one 32-bit word per clock, onto the write port of the processor's instruction memory. When the last word has gone out it raises a one-cycle release pulse so that the processor can start.

A host sets up a copy over a plain 32-bit register bus. It writes a byte offset into the boot memory, a destination byte address and a length in words. It then sets the start bit in the control register and polls that bit until it drops. Alternatively the host sets the arm bit once, and after that every power-up pulse replays the copy without further host action. The host can also read and write the boot memory itself and four image pointer/size words. Those four words are only stored, so that the boot program can read them.

Top module: `retboot_copier`

## Requirements
- R1: The registers at byte offsets 0x004 (source byte offset), 0x008 (destination byte address), 0x00C (length in words) and 0x090, 0x094, 0x098, 0x09C (image words) read back the last 32-bit value written, including bit 31 of 0x094.
- R2: Boot memory word i is written and read at byte offset 0x400 + 4*i, for i from 0 to DEPTH-1.
- R3: Writing 0x000 with bit 31 set while idle starts a copy. Word k (k from 0) appears on the instruction port two cycles after the cycle of the start write, plus k cycles. Its address is destination + 4*k and its data is boot word (source/4 + k). The write enable is high for exactly those cycles.
- R4: Bit 31 of 0x000 reads 1 from the cycle after the start until the copy ends, then reads 0. Bit 0 of 0x010 is cleared when a copy starts and reads 1 once the copy has finished.
- R5: A copy of N words ends with exactly one one-cycle release pulse, N+2 cycles after the triggering cycle.
- R6: A length of zero performs no instruction-memory write but still ends with done and the release pulse.
- R7: When source/4 + length exceeds DEPTH, the copy stops after word DEPTH-1. A source at or past the end of the memory writes nothing.
- R8: A power-up pulse starts a copy only while the arm bit (bit 30 of 0x000) is 1. With the arm bit at 0 it has no effect.
- R9: A start write or a power-up pulse that arrives while a copy runs is ignored. A start write and a power-up pulse in the same idle cycle start a single copy.
- R10: Reset returns every register to zero, including control and status, and leaves the boot memory contents intact.
- R11: Every write to 0x000 loads bit 30 into the arm bit, and that bit reads back at bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register bus byte address |
| regWrEn | input | 1 | Register bus write strobe |
| regWrData | input | 32 | Register bus write data |
| regRdData | output | 32 | Register bus read data (combinational) |
| powerUp | input | 1 | Power-up event pulse |
| imemWe | output | 1 | Instruction memory write enable |
| imemAddr | output | 32 | Instruction memory byte address |
| imemData | output | 32 | Instruction memory write data |
| cpuRelease | output | 1 | One-cycle processor release pulse |

## Verification
The two triggers, a host start write and a power-up pulse, can fall in the same cycle. A trigger can also land while a copy is already running. The bench arms the block and then presents the start write and the power-up pulse together. It keeps both asserted during the following busy cycles and checks that exactly one copy came out: the expected word count, one release pulse, and that pulse in the cycle computed from the length. A full sweep of source offset against length, run on a 16-word memory, compares every written address, data word and cycle against arithmetic in the bench.

// File: rtl/retboot_pkg.sv
package retboot_pkg;
  localparam int OFS_CTRL = 'h000;
  localparam int OFS_SRC  = 'h004;
  localparam int OFS_DST  = 'h008;
  localparam int OFS_CNT  = 'h00C;
  localparam int OFS_STAT = 'h010;
  localparam int OFS_IMG  = 'h090;
  localparam int OFS_MEM  = 'h400;
  localparam int IMG_REGS = 4;
  localparam int START_BIT = 31;
  localparam int ARM_BIT   = 30;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } copyStrobe_t;
endpackage

// File: rtl/retboot_ctrl.sv
module retboot_ctrl
  import retboot_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             wrStart,
  input  logic             wrArm,
  input  logic             powerUp,
  input  logic [CNT_W-1:0] effCount,
  output copyStrobe_t      strobe,
  output logic             busy,
  output logic             arm,
  output logic             done
);
  logic [CNT_W-1:0] remaining;
  logic go;

  assign go = !busy && ((ctrlWr && wrStart) || (powerUp && arm));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      arm       <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
    end else begin
      if (ctrlWr) arm <= wrArm;
      if (go) begin
        busy      <= 1'b1;
        remaining <= effCount;
        done      <= 1'b0;
      end else if (busy) begin
        if (remaining != '0) begin
          remaining <= remaining - CNT_W'(1);
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load   = go;
    strobe.step   = busy && (remaining != '0);
    strobe.finish = busy && (remaining == '0);
  end

  // R9: a running copy counts down undisturbed by new triggers
  p_countdown_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && (remaining != '0) |=> busy && (remaining == $past(remaining) - CNT_W'(1)));
  // R4: done drops as a copy begins
  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !done);
  // R4: the end of the count leaves the block idle with done set
  p_finish_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && (remaining == '0) |=> !busy && done);
endmodule

// File: rtl/retboot_dpath.sv
module retboot_dpath
  import retboot_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 9,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  copyStrobe_t       strobe,
  input  logic              busy,
  input  logic              arm,
  input  logic              done,
  output logic [CNT_W-1:0]  effCount,
  output logic              imemWe,
  output logic [31:0]       imemAddr,
  output logic [31:0]       imemData,
  output logic              cpuRelease
);
  localparam int MEM_END = OFS_MEM + 4 * DEPTH;

  logic [31:0] srcReg, dstReg, cntReg;
  logic [31:0] imgReg [IMG_REGS];
  logic [31:0] bootMem [DEPTH];
  logic [IDX_W-1:0] rdIdx;
  logic [31:0] dstPtr;

  logic [31:0] addrExt;
  logic memHit, imgHit;
  logic [IDX_W-1:0] memIdx;
  logic [1:0] imgIdx;
  logic [31:0] srcWord, avail;

  assign addrExt = 32'(regAddr);
  assign memHit  = (addrExt >= 32'(OFS_MEM)) && (addrExt < 32'(MEM_END));
  assign memIdx  = IDX_W'((addrExt - 32'(OFS_MEM)) >> 2);
  assign imgHit  = (addrExt >= 32'(OFS_IMG)) && (addrExt < 32'(OFS_IMG + 4 * IMG_REGS));
  assign imgIdx  = regAddr[3:2];

  // Length clipped to the words left between the source and the memory end
  always_comb begin
    srcWord = {2'b00, srcReg[31:2]};
    avail   = 32'(DEPTH) - srcWord;
    if (srcWord >= 32'(DEPTH))  effCount = '0;
    else if (cntReg > avail)    effCount = CNT_W'(avail);
    else                        effCount = CNT_W'(cntReg);
  end

  // Boot memory has no reset so that it survives a block reset
  always_ff @(posedge clk) begin
    if (regWrEn && memHit) bootMem[memIdx] <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg     <= '0;
      dstReg     <= '0;
      cntReg     <= '0;
      for (int i = 0; i < IMG_REGS; i++) imgReg[i] <= '0;
      rdIdx      <= '0;
      dstPtr     <= '0;
      imemWe     <= 1'b0;
      imemAddr   <= '0;
      imemData   <= '0;
      cpuRelease <= 1'b0;
    end else begin
      if (regWrEn) begin
        if (addrExt == 32'(OFS_SRC)) srcReg <= regWrData;
        if (addrExt == 32'(OFS_DST)) dstReg <= regWrData;
        if (addrExt == 32'(OFS_CNT)) cntReg <= regWrData;
        if (imgHit) imgReg[imgIdx] <= regWrData;
      end
      if (strobe.load) begin
        rdIdx  <= IDX_W'(srcReg[31:2]);
        dstPtr <= dstReg;
      end
      imemWe <= strobe.step;
      if (strobe.step) begin
        imemAddr <= dstPtr;
        imemData <= bootMem[rdIdx];
        rdIdx    <= rdIdx + IDX_W'(1);
        dstPtr   <= dstPtr + 32'd4;
      end
      cpuRelease <= strobe.finish;
    end
  end

  always_comb begin
    regRdData = '0;
    if (memHit) begin
      regRdData = bootMem[memIdx];
    end else if (imgHit) begin
      regRdData = imgReg[imgIdx];
    end else begin
      case (addrExt)
        32'(OFS_CTRL): begin
          regRdData[START_BIT] = busy;
          regRdData[ARM_BIT]   = arm;
        end
        32'(OFS_SRC):  regRdData = srcReg;
        32'(OFS_DST):  regRdData = dstReg;
        32'(OFS_CNT):  regRdData = cntReg;
        32'(OFS_STAT): regRdData[0] = done;
        default:       regRdData = '0;
      endcase
    end
  end

  // R3: instruction writes only follow a busy cycle
  p_we_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    imemWe |-> $past(busy));
  // R3: back-to-back writes step the address by one word
  p_stride_r3: assert property (@(posedge clk) disable iff (!rstN)
    imemWe && $past(imemWe) |-> imemAddr == $past(imemAddr) + 32'd4);
  // R5: the release pulse lasts one cycle
  p_release_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease |=> !cpuRelease);
  // R5: release coincides with done being set and no write in flight
  p_release_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease |-> done && !imemWe);
endmodule

// File: rtl/retboot_copier.sv
module retboot_copier
  import retboot_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              powerUp,
  output logic              imemWe,
  output logic [31:0]       imemAddr,
  output logic [31:0]       imemData,
  output logic              cpuRelease
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  copyStrobe_t strobe;
  logic busy, arm, done, ctrlWr;
  logic [CNT_W-1:0] effCount;

  assign ctrlWr = regWrEn && (32'(regAddr) == 32'(OFS_CTRL));

  retboot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .wrStart  (regWrData[START_BIT]),
    .wrArm    (regWrData[ARM_BIT]),
    .powerUp  (powerUp),
    .effCount (effCount),
    .strobe   (strobe),
    .busy     (busy),
    .arm      (arm),
    .done     (done)
  );

  retboot_dpath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .strobe     (strobe),
    .busy       (busy),
    .arm        (arm),
    .done       (done),
    .effCount   (effCount),
    .imemWe     (imemWe),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .cpuRelease (cpuRelease)
  );
endmodule

// File: tb/retboot_copier_tb.sv
module retboot_copier_tb;
  localparam int DEPTH = 16;
  localparam int LOGN  = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic powerUp = 1'b0;
  logic imemWe, cpuRelease;
  logic [31:0] imemAddr, imemData;

  always #4 clk = ~clk;

  retboot_copier #(.DEPTH(DEPTH), .ADDR_W(12)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .powerUp(powerUp),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .cpuRelease(cpuRelease)
  );

  int checks = 0, errors = 0, cyc = 0, wrTotal = 0, relTotal = 0, lastRel = 0;
  bit finished = 0;
  logic [31:0] logA [LOGN];
  logic [31:0] logD [LOGN];
  int logC [LOGN];
  logic [31:0] shadow [DEPTH];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (imemWe === 1'b1 && wrTotal < LOGN) begin
      logA[wrTotal] = imemAddr;
      logD[wrTotal] = imemData;
      logC[wrTotal] = cyc;
      wrTotal = wrTotal + 1;
    end
    if (cpuRelease === 1'b1) begin
      relTotal = relTotal + 1;
      lastRel = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = 12'(addr); regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = 12'(addr); regWrEn = 1'b0;
    #1 data = regRdData;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC3A5_0000 ^ (32'(i) * 32'h0101_0203);
  endfunction

  function automatic int effOf(input int s, input int c);
    if (s >= DEPTH) return 0;
    if (s + c > DEPTH) return DEPTH - s;
    return c;
  endfunction

  task automatic waitIdle();
    regAddr = 12'h000;
    #1;
    for (int k = 0; k < DEPTH + 10; k++) begin
      if (regRdData[31] == 1'b0) break;
      @(negedge clk); #1;
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic checkWrites(input string tag, input int base, input int s, input int e,
                             input logic [31:0] dst, input int t0);
    int n;
    n = wrTotal - base;
    chk(n == e, {tag, " word count"}, 32'(n), 32'(e));
    for (int k = 0; k < e && k < n; k++) begin
      chk(logA[base+k] == dst + 32'(4*k), {tag, " address"}, logA[base+k], dst + 32'(4*k));
      chk(logD[base+k] == shadow[s+k], {tag, " data"}, logD[base+k], shadow[s+k]);
      chk(logC[base+k] == t0 + 2 + k, {tag, " write cycle"}, 32'(logC[base+k]), 32'(t0+2+k));
    end
  endtask

  task automatic copyRun(input int s, input int c, input logic [31:0] dst, input bit viaPower);
    int base, rbase, t0, e;
    logic [31:0] v;
    string tag;
    e = effOf(s, c);
    tag = (e == 0) ? "R6" : ((e != c) ? "R7" : "R3");
    wr('h004, 32'(s*4)); wr('h008, dst); wr('h00C, 32'(c));
    if (viaPower) wr('h000, 32'h4000_0000);
    base = wrTotal; rbase = relTotal;
    @(negedge clk);
    if (viaPower) powerUp = 1'b1;
    else begin regAddr = 12'h000; regWrData = 32'h8000_0000; regWrEn = 1'b1; end
    #1 t0 = cyc;
    @(negedge clk);
    powerUp = 1'b0; regWrEn = 1'b0; regAddr = 12'h000;
    #1 chk(regRdData[31] == 1'b1, viaPower ? "R8 power-up start busy" : "R4 start bit high",
           32'(regRdData[31]), 32'd1);
    waitIdle();
    chk(regRdData[31] == 1'b0, "R4 start bit cleared", 32'(regRdData[31]), 32'd0);
    checkWrites(tag, base, s, e, dst, t0);
    chk(relTotal - rbase == 1, "R5 release count", 32'(relTotal - rbase), 32'd1);
    chk(lastRel == t0 + 2 + e, "R5 release cycle", 32'(lastRel), 32'(t0 + 2 + e));
    rd('h010, v);
    chk(v == 32'd1, "R4 done status", v, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, rbase, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state of control, status and setup registers
    rd('h000, v); chk(v == 0, "R10 ctrl after reset", v, 0);
    rd('h010, v); chk(v == 0, "R10 status after reset", v, 0);
    rd('h004, v); chk(v == 0, "R10 src after reset", v, 0);
    rd('h00C, v); chk(v == 0, "R10 count after reset", v, 0);

    // R2: boot memory fill and readback
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = pat(i);
      wr('h400 + 4*i, shadow[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      rd('h400 + 4*i, v);
      chk(v == shadow[i], "R2 boot memory readback", v, shadow[i]);
    end

    // R1: setup and image register readback
    wr('h004, 32'h0000_0024); wr('h008, 32'hDEAD_BEE0); wr('h00C, 32'h0000_0123);
    wr('h090, 32'h1111_2220); wr('h094, 32'h8000_1234);
    wr('h098, 32'h3333_4440); wr('h09C, 32'h0000_0567);
    rd('h004, v); chk(v == 32'h0000_0024, "R1 src readback", v, 32'h0000_0024);
    rd('h008, v); chk(v == 32'hDEAD_BEE0, "R1 dst readback", v, 32'hDEAD_BEE0);
    rd('h00C, v); chk(v == 32'h0000_0123, "R1 count readback", v, 32'h0000_0123);
    rd('h090, v); chk(v == 32'h1111_2220, "R1 image 0", v, 32'h1111_2220);
    rd('h094, v); chk(v == 32'h8000_1234, "R1 image 1 load flag", v, 32'h8000_1234);
    rd('h098, v); chk(v == 32'h3333_4440, "R1 image 2", v, 32'h3333_4440);
    rd('h09C, v); chk(v == 32'h0000_0567, "R1 image 3", v, 32'h0000_0567);

    // R11: arm bit readback
    wr('h000, 32'h4000_0000);
    rd('h000, v); chk(v == 32'h4000_0000, "R11 arm readback", v, 32'h4000_0000);
    wr('h000, 32'h0000_0000);
    rd('h000, v); chk(v == 32'h0, "R11 arm cleared", v, 32'h0);

    // R8: power-up with arm at 0 is ignored
    base = wrTotal; rbase = relTotal;
    @(negedge clk); powerUp = 1'b1;
    @(negedge clk); powerUp = 1'b0;
    repeat (4) @(negedge clk);
    chk(wrTotal == base, "R8 no write when disarmed", 32'(wrTotal - base), 0);
    chk(relTotal == rbase, "R8 no release when disarmed", 32'(relTotal - rbase), 0);
    rd('h000, v); chk(v[31] == 1'b0, "R8 idle when disarmed", 32'(v[31]), 0);

    // R3 R6 R7 R8: sweep of source offset against length
    for (int s = 0; s < DEPTH + 2; s++) begin
      for (int c = 0; c < DEPTH + 3; c++) begin
        copyRun(s, c, 32'h0001_0000 + 32'(s * 256), ((s + c) % 3) == 0);
      end
    end

    // R9: simultaneous start and power-up, then repeated triggers while busy
    wr('h004, 32'h0); wr('h008, 32'h0000_2000); wr('h00C, 32'd8);
    wr('h000, 32'h4000_0000);
    base = wrTotal; rbase = relTotal;
    @(negedge clk);
    regAddr = 12'h000; regWrData = 32'hC000_0000; regWrEn = 1'b1; powerUp = 1'b1;
    #1 t0 = cyc;
    @(negedge clk);
    @(negedge clk); regWrEn = 1'b0;
    @(negedge clk); powerUp = 1'b0;
    waitIdle();
    checkWrites("R9", base, 0, 8, 32'h0000_2000, t0);
    chk(relTotal - rbase == 1, "R9 single release", 32'(relTotal - rbase), 1);
    chk(lastRel == t0 + 10, "R9 release cycle", 32'(lastRel), 32'(t0 + 10));

    // R10: reset clears registers but keeps boot memory
    wr('h004, 32'h0000_0008); wr('h094, 32'h8000_0040);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    rd('h004, v); chk(v == 0, "R10 src cleared", v, 0);
    rd('h008, v); chk(v == 0, "R10 dst cleared", v, 0);
    rd('h094, v); chk(v == 0, "R10 image cleared", v, 0);
    rd('h000, v); chk(v == 0, "R10 ctrl cleared", v, 0);
    rd('h010, v); chk(v == 0, "R10 done cleared", v, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd('h400 + 4*i, v);
      chk(v == shadow[i], "R10 boot memory kept", v, shadow[i]);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule